// File: doc/BRIEF.md
# SMBus Clock-Low Timeout and Post-Write Stretch Guard

This block sits beside the byte-level protocol engine of a serial management slave. It does two things. It watches the synchronised SCL level. If the line stays low for too long, it sends the protocol engine a one-cycle reset pulse. After a timeout reset, the engine ignores bus activity until it sees a fresh START. The check runs in every bus phase, not only during data bytes.

The block also owns the open-drain pull-low enable for SCL. The engine raises a strobe when the STOP that closes any write command is seen. This covers identification register writes and seed writes alike. From then on, the guard holds the clock low until the storage model reports that the internal write is done. While the guard is stretching, it freezes its own low-time counter, so its own stretch never looks like a stuck bus.

Both limits are parameters in system clock cycles:
- `TIMEOUT_CYC` is the SCL-low limit (25 ms at the system clock).
- `WRITE_CYC` is the longest write time. It bounds the stretch if the completion signal never comes.

All pins are plain level or strobe controls. No data passes through the block, so there is no valid/ready handshake.

Top module: `scl_hold_guard`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `scl_pull_low` and `proto_rst` are both 0.
- R2: If `scl_in` is sampled low on `TIMEOUT_CYC` consecutive rising edges while no stretch is active, `proto_rst` is 1 for exactly the one cycle after the last of those edges.
- R3: When `scl_in` is sampled high (outside a stretch), the low-time count clears. A low period shorter than `TIMEOUT_CYC` samples never produces a pulse.
- R4: One low period gives at most one `proto_rst` pulse, however long it lasts. `scl_in` must be sampled high before another pulse can occur.
- R5: When `wr_stop` is sampled 1 while no stretch is active, `scl_pull_low` is 1 from the next cycle.
- R6: When `wr_done` is sampled 1 during a stretch, `scl_pull_low` returns to 0 in the next cycle.
- R7: Without `wr_done`, a stretch lasts exactly `WRITE_CYC` cycles and then `scl_pull_low` returns to 0.
- R8: A `wr_done` pulse while no stretch is active is ignored: `scl_pull_low` stays 0.
- R9: A `wr_stop` strobe during a stretch is ignored and does not restart the `WRITE_CYC` window.
- R10: While `scl_pull_low` is 1, the low-time count is frozen and no `proto_rst` is produced. After release, counting resumes from the retained value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_in | input | 1 | Synchronised SCL line level (1 = high) |
| wr_stop | input | 1 | One-cycle strobe from the engine: STOP seen at the end of a write command |
| wr_done | input | 1 | Storage model reports that the internal write has finished |
| scl_pull_low | output | 1 | Open-drain enable; 1 drives SCL low |
| proto_rst | output | 1 | One-cycle reset pulse to the protocol engine on an SCL-low timeout |

## Verification
The bench sweeps the length of an SCL low period across the timeout threshold. A design with an off-by-one limit would pulse one cycle early or late. A design that fails to latch the event would pulse repeatedly during a long low period. The bench also sweeps the arrival cycle of `wr_done` through the whole stretch window and past its end. A late release, or a stretch that ignores the bound, shows up as wrong `scl_pull_low` cycles. Two further cases are tested:
- The bench drives a stretch longer than the timeout threshold and then resumes a partly counted low period. A counter that is not frozen would reset the engine during its own stretch; a counter that is cleared instead of frozen would pulse late.
- A stray `wr_done` and a repeated `wr_stop` are driven. A design that does not ignore them would start a spurious stretch or extend a running one.

// File: rtl/scl_guard_pkg.sv
package scl_guard_pkg;

  typedef enum logic {
    HOLD_OFF = 1'b0,
    HOLD_ON  = 1'b1
  } hold_state_e;

  function automatic int unsigned cnt_width(input int unsigned limit);
    return (limit < 2) ? 1 : $clog2(limit + 1);
  endfunction

endpackage

// File: rtl/scl_low_timer.sv
module scl_low_timer
  import scl_guard_pkg::*;
#(
  parameter int unsigned LIMIT = 6_250_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic freeze,
  output logic tmo_pulse
);
  localparam int unsigned CW = cnt_width(LIMIT);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] low_cnt;
  logic          fired;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      low_cnt   <= '0;
      fired     <= 1'b0;
      tmo_pulse <= 1'b0;
    end else if (freeze) begin
      tmo_pulse <= 1'b0;
    end else if (scl_in) begin
      low_cnt   <= '0;
      fired     <= 1'b0;
      tmo_pulse <= 1'b0;
    end else if (!fired) begin
      if (low_cnt == LAST) begin
        fired     <= 1'b1;
        tmo_pulse <= 1'b1;
      end else begin
        low_cnt   <= low_cnt + 1'b1;
        tmo_pulse <= 1'b0;
      end
    end else begin
      tmo_pulse <= 1'b0;
    end
  end
endmodule

// File: rtl/write_stretch_fsm.sv
module write_stretch_fsm
  import scl_guard_pkg::*;
#(
  parameter int unsigned WRITE_CYC = 2_500_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_stop,
  input  logic wr_done,
  output logic hold
);
  localparam int unsigned HW = cnt_width(WRITE_CYC);
  localparam logic [HW-1:0] HLAST = HW'(WRITE_CYC - 1);

  hold_state_e   state, state_nx;
  logic [HW-1:0] hcnt, hcnt_nx;

  always_comb begin
    state_nx = state;
    hcnt_nx  = hcnt;
    unique case (state)
      HOLD_OFF: begin
        if (wr_stop) begin
          state_nx = HOLD_ON;
          hcnt_nx  = '0;
        end
      end
      HOLD_ON: begin
        if (wr_done || hcnt == HLAST) begin
          state_nx = HOLD_OFF;
          hcnt_nx  = '0;
        end else begin
          hcnt_nx = hcnt + 1'b1;
        end
      end
      default: state_nx = HOLD_OFF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= HOLD_OFF;
      hcnt  <= '0;
    end else begin
      state <= state_nx;
      hcnt  <= hcnt_nx;
    end
  end

  assign hold = (state == HOLD_ON);
endmodule

// File: rtl/scl_hold_guard.sv
module scl_hold_guard #(
  parameter int unsigned TIMEOUT_CYC = 6_250_000,
  parameter int unsigned WRITE_CYC   = 2_500_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic wr_stop,
  input  logic wr_done,
  output logic scl_pull_low,
  output logic proto_rst
);
  logic hold;

  write_stretch_fsm #(.WRITE_CYC(WRITE_CYC)) u_stretch (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_stop (wr_stop),
    .wr_done (wr_done),
    .hold    (hold)
  );

  scl_low_timer #(.LIMIT(TIMEOUT_CYC)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_in    (scl_in),
    .freeze    (hold),
    .tmo_pulse (proto_rst)
  );

  assign scl_pull_low = hold;
endmodule

// File: rtl/scl_guard_chk.sv
module scl_guard_chk #(
  parameter int unsigned WRITE_CYC = 2_500_000
) (
  input logic clk,
  input logic rst_n,
  input logic scl_in,
  input logic wr_stop,
  input logic wr_done,
  input logic scl_pull_low,
  input logic proto_rst
);
  logic [31:0] hold_len;

  always_ff @(posedge clk) begin
    if (!rst_n)            hold_len <= '0;
    else if (scl_pull_low) hold_len <= hold_len + 1'b1;
    else                   hold_len <= '0;
  end

  AST_RST_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    proto_rst |=> !proto_rst); // R2
  AST_HIGH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_in && !scl_pull_low) |=> !proto_rst); // R3
  AST_HOLD_START: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stop && !scl_pull_low) |=> scl_pull_low); // R5
  AST_DONE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_done && scl_pull_low) |=> !scl_pull_low); // R6
  AST_HOLD_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    hold_len <= WRITE_CYC); // R7
  AST_IDLE_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_stop && !scl_pull_low) |=> !scl_pull_low); // R8
  AST_FROZEN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    scl_pull_low |=> !proto_rst); // R10
endmodule

bind scl_hold_guard scl_guard_chk #(.WRITE_CYC(WRITE_CYC)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .scl_in       (scl_in),
  .wr_stop      (wr_stop),
  .wr_done      (wr_done),
  .scl_pull_low (scl_pull_low),
  .proto_rst    (proto_rst)
);

// File: tb/tb_scl_hold_guard.sv
`timescale 1ns/1ps
module tb_scl_hold_guard;
  localparam int unsigned T = 8;
  localparam int unsigned W = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic master_scl = 1'b1;
  logic wr_stop = 1'b0;
  logic wr_done = 1'b0;
  logic scl_pull_low, proto_rst;
  logic scl_in;
  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  // wired-AND bus: the master releases high, the guard may pull low
  assign scl_in = master_scl & ~scl_pull_low;

  always #2 clk = ~clk;

  scl_hold_guard #(.TIMEOUT_CYC(T), .WRITE_CYC(W)) dut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .wr_stop(wr_stop),
    .wr_done(wr_done), .scl_pull_low(scl_pull_low), .proto_rst(proto_rst)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(4 * 20000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    idle(3);
    chk("R1 pull during reset", scl_pull_low, 1'b0);
    chk("R1 rst during reset", proto_rst, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 pull after reset", scl_pull_low, 1'b0);
    chk("R1 rst after reset", proto_rst, 1'b0);

    // R2 R3 R4: sweep low-period length across the threshold
    for (int len = 1; len <= T + 5; len++) begin
      int pulses;
      pulses = 0;
      master_scl = 1'b0;
      for (int i = 1; i <= len; i++) begin
        @(negedge clk);
        if (proto_rst) pulses++;
        if (i == T) chk("R2 pulse on limit sample", proto_rst, 1'b1);
        else if (i < T) chk("R3 no pulse below limit", proto_rst, 1'b0);
        else chk("R4 single pulse per low period", proto_rst, 1'b0);
      end
      master_scl = 1'b1;
      @(negedge clk);
      chk("R3 high clears", proto_rst, 1'b0);
      checks++;
      if (pulses != ((len >= T) ? 1 : 0)) begin
        fails++;
        $display("FAIL R4 len=%0d actual=%0d expected=%0d", len, pulses, (len >= T) ? 1 : 0);
      end
      idle(2);
    end

    // R5 R6 R7 R10: sweep wr_done arrival across and past the window
    for (int d = 1; d <= W + 2; d++) begin
      int rel;
      rel = (d < W) ? d : W;
      wr_stop = 1'b1;
      @(negedge clk);
      wr_stop = 1'b0;
      chk("R5 stretch starts", scl_pull_low, 1'b1);
      for (int k = 1; k <= W + 1; k++) begin
        wr_done = (k == d);
        @(negedge clk);
        wr_done = 1'b0;
        if (d < W) chk("R6 release on done", scl_pull_low, k < rel);
        else chk("R7 release on bound", scl_pull_low, k < rel);
        chk("R10 no timeout during stretch", proto_rst, 1'b0);
      end
      idle(2);
    end

    // R9: second strobe mid-stretch does not extend
    wr_stop = 1'b1;
    @(negedge clk);
    wr_stop = 1'b0;
    for (int k = 1; k <= W + 1; k++) begin
      wr_stop = (k == 4);
      @(negedge clk);
      wr_stop = 1'b0;
      chk("R9 repeat strobe ignored", scl_pull_low, k < W);
    end
    idle(2);

    // R8: stray wr_done while idle
    wr_done = 1'b1;
    @(negedge clk);
    wr_done = 1'b0;
    for (int k = 0; k < 3; k++) begin
      chk("R8 stray done ignored", scl_pull_low, 1'b0);
      @(negedge clk);
    end

    // R10: partial count frozen then resumed
    master_scl = 1'b0;
    for (int i = 1; i <= 5; i++) begin
      @(negedge clk);
      chk("R10 pre-count", proto_rst, 1'b0);
    end
    wr_stop = 1'b1;
    @(negedge clk);              // 6th low sample counted, stretch begins
    wr_stop = 1'b0;
    chk("R10 stretch on", scl_pull_low, 1'b1);
    @(negedge clk);              // frozen
    chk("R10 frozen quiet", proto_rst, 1'b0);
    wr_done = 1'b1;
    @(negedge clk);              // frozen, release
    wr_done = 1'b0;
    chk("R10 released", scl_pull_low, 1'b0);
    chk("R10 no pulse at release", proto_rst, 1'b0);
    @(negedge clk);              // 7th low sample
    chk("R10 resumed count 7", proto_rst, 1'b0);
    @(negedge clk);              // 8th low sample
    chk("R10 pulse from retained count", proto_rst, 1'b1);
    @(negedge clk);
    chk("R10 pulse single", proto_rst, 1'b0);
    master_scl = 1'b1;
    idle(2);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule